// File: doc/BRIEF.md
# Boundary-Scan Test Port

This block puts a serial test port around a small device that has a few input pins and a few output pins. Five wires control it: a test clock, a mode-select line, serial data in, serial data out with its enable, and an optional asynchronous reset that is active low. A sixteen-state controller follows the mode-select line. An instruction register picks which data register sits between serial in and serial out: a one-bit bypass stage, or a boundary register that holds one cell per device pin.

Every output pin passes through a multiplexer. The multiplexer passes either the core's functional value or a value held in that cell's update latch. The latch values reach the pins only when the drive-pins instruction is in effect. Under the other instructions the device keeps working, and the boundary register only takes snapshots or is preloaded. Input pins always pass straight through to the core, and their cells observe the pins.

Top module: `bscan_port`

## Requirements
- R1: While `test_rst_n` is low, the controller is held in Test-Logic-Reset and the bypass instruction is selected. `ser_oe` is low at once, and `pad_out` equals `core_out`.
- R2: `mode_sel` is sampled on rising clock edges and follows the standard sixteen-state graph. Five rising edges with `mode_sel` high reach Test-Logic-Reset from any state, including Shift-DR.
- R3: `ser_out` and `ser_oe` change only on falling clock edges. `ser_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R4: The instruction register is 2 bits wide. It captures `01` in Capture-IR and shifts least significant bit first. A new code takes effect only on the falling edge in Update-IR. The codes are: `00` drive pins, `01` sample/preload, `11` bypass. Code `10` acts as bypass.
- R5: Under bypass, Capture-DR loads 0 into the single bypass stage. Each bit presented on `ser_in` appears on `ser_out` one clock later, and the pins stay functional.
- R6: Under sample/preload, Capture-DR loads `core_out` into the output cells and `pad_in` into the input cells. The first bit out is output cell 0, then the remaining output cells in ascending order, then input cells 0 upward. Shifted data is preloaded while the pins keep following `core_out`.
- R7: The output-cell update latches load only on the falling edge in Update-DR while a boundary instruction is selected. `pad_out` does not change while data is being shifted.
- R8: Under drive pins, `pad_out` shows the update latches from Update-IR onward and ignores `core_out`. Capture still snapshots the cells.
- R9: In Test-Logic-Reset, `pad_out` equals `core_out` whatever the latches or the instruction register hold.
- R10: `core_in` always equals `pad_in`.
- R11: Reaching Test-Logic-Reset through `mode_sel` makes bypass the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Serial test clock |
| test_rst_n | input | 1 | Asynchronous controller reset, active low |
| mode_sel | input | 1 | Controller steering line, sampled on the rising edge |
| ser_in | input | 1 | Serial data in, sampled on the rising edge in shift states |
| ser_out | output | 1 | Serial data out, updated on the falling edge |
| ser_oe | output | 1 | Output enable for `ser_out`, high only in shift states |
| pad_in | input | N_IN | Values arriving on the device input pins |
| core_in | output | N_IN | Input pin values passed to the core |
| core_out | input | N_OUT | Functional values from the core for the output pins |
| pad_out | output | N_OUT | Values driven onto the device output pins |

## Verification
Assertions check four things on every clock. The serial output enable matches the shift states. The instruction register and the update latches hold outside their update states. The pins follow the core in Test-Logic-Reset. Under bypass, each serial bit emerges one clock after it went in. The bench scenarios cover what only a full sequence can show: the order of the captured bits, preloading under sample and then driving under the drive-pins instruction, the undefined code acting as bypass, the five-edge escape from Shift-DR with its intervening update, and an asynchronous reset during a shift.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DRSEL, ST_DRCAP, ST_DRSHF, ST_DREX1, ST_DRPAU, ST_DREX2, ST_DRUPD,
      ST_IRSEL, ST_IRCAP, ST_IRSHF, ST_IREX1, ST_IRPAU, ST_IREX2, ST_IRUPD
   } tap_st_t;

   function automatic tap_st_t tap_next(input tap_st_t s, input logic m);
      tap_st_t n;
      case (s)
         ST_RESET: n = m ? ST_RESET : ST_IDLE;
         ST_IDLE:  n = m ? ST_DRSEL : ST_IDLE;
         ST_DRSEL: n = m ? ST_IRSEL : ST_DRCAP;
         ST_DRCAP: n = m ? ST_DREX1 : ST_DRSHF;
         ST_DRSHF: n = m ? ST_DREX1 : ST_DRSHF;
         ST_DREX1: n = m ? ST_DRUPD : ST_DRPAU;
         ST_DRPAU: n = m ? ST_DREX2 : ST_DRPAU;
         ST_DREX2: n = m ? ST_DRUPD : ST_DRSHF;
         ST_DRUPD: n = m ? ST_DRSEL : ST_IDLE;
         ST_IRSEL: n = m ? ST_RESET : ST_IRCAP;
         ST_IRCAP: n = m ? ST_IREX1 : ST_IRSHF;
         ST_IRSHF: n = m ? ST_IREX1 : ST_IRSHF;
         ST_IREX1: n = m ? ST_IRUPD : ST_IRPAU;
         ST_IRPAU: n = m ? ST_IREX2 : ST_IRPAU;
         ST_IREX2: n = m ? ST_IRUPD : ST_IRSHF;
         ST_IRUPD: n = m ? ST_DRSEL : ST_IDLE;
         default:  n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bscan_ctrl.sv
module bscan_ctrl
   import bscan_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    mode_sel,
   output tap_st_t st
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_RESET;
      else        st <= tap_next(st, mode_sel);
   end

   // R2: holding mode_sel high keeps the controller parked in reset
   assert_reset_park_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RESET && mode_sel) |=> (st == ST_RESET));

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
   import bscan_pkg::*;
#(
   parameter int IR_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  tap_st_t         st,
   input  logic            din,
   output logic [IR_W-1:0] ir_q,
   output logic            sh_lsb
);

   localparam logic [IR_W-1:0] CAPT_PAT = IR_W'(1);
   localparam logic [IR_W-1:0] PASS_OP  = '1;

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sh_q <= CAPT_PAT;
      else if (st == ST_IRCAP)   sh_q <= CAPT_PAT;
      else if (st == ST_IRSHF)   sh_q <= {din, sh_q[IR_W-1:1]};
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)                ir_q <= PASS_OP;
      else if (st == ST_RESET)   ir_q <= PASS_OP;
      else if (st == ST_IRUPD)   ir_q <= sh_q;
   end

   assign sh_lsb = sh_q[0];

   // R4: the active code only moves in Update-IR (or Test-Logic-Reset)
   assert_ir_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IRUPD && st != ST_RESET) |-> $stable(ir_q));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
   parameter int N_CELLS = 8,
   parameter int N_LATCH = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic               shf_en,
   input  logic               upd_en,
   input  logic               din,
   input  logic [N_CELLS-1:0] cap_vec,
   output logic               chain_lsb,
   output logic [N_LATCH-1:0] upd_out
);

   logic [N_CELLS-1:0] stage;

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      logic nxt;
      logic q;
      if (i == N_CELLS - 1) begin : g_head
         assign nxt = din;
      end else begin : g_body
         assign nxt = stage[i+1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= 1'b0;
         else if (cap_en) q <= cap_vec[i];
         else if (shf_en) q <= nxt;
      end
      assign stage[i] = q;

      if (i < N_LATCH) begin : g_hold
         logic hq;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)      hq <= 1'b0;
            else if (upd_en) hq <= q;
         end
         assign upd_out[i] = hq;
      end
   end

   assign chain_lsb = stage[0];

   // R7: forced pin values change only on the Update-DR falling edge
   assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |-> $stable(upd_out));

endmodule

// File: rtl/bscan_port.sv
module bscan_port
   import bscan_pkg::*;
#(
   parameter int N_IN  = 4,
   parameter int N_OUT = 4,
   parameter int IR_W  = 2
) (
   input  logic             test_clk,
   input  logic             test_rst_n,
   input  logic             mode_sel,
   input  logic             ser_in,
   output logic             ser_out,
   output logic             ser_oe,
   input  logic [N_IN-1:0]  pad_in,
   output logic [N_IN-1:0]  core_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_OUT-1:0] pad_out
);

   localparam int N_CELLS = N_IN + N_OUT;
   localparam logic [IR_W-1:0] OP_DRIVE = '0;
   localparam logic [IR_W-1:0] OP_SNAP  = IR_W'(1);

   if (N_IN < 1 || N_OUT < 1) begin : g_bad_pins
      $error("bscan_port: pin counts must be positive");
   end
   if (IR_W < 2) begin : g_bad_ir
      $error("bscan_port: instruction width must be at least 2");
   end

   tap_st_t            st;
   logic [IR_W-1:0]    ir_q;
   logic               ir_lsb;
   logic               bnd_sel;
   logic               chain_lsb;
   logic               byp_q;
   logic [N_OUT-1:0]   upd_out;
   logic               drive_on;
   logic               in_shift;

   bscan_ctrl u_ctrl (
      .clk      (test_clk),
      .rst_n    (test_rst_n),
      .mode_sel (mode_sel),
      .st       (st)
   );

   bscan_ir #(.IR_W(IR_W)) u_ir (
      .clk    (test_clk),
      .rst_n  (test_rst_n),
      .st     (st),
      .din    (ser_in),
      .ir_q   (ir_q),
      .sh_lsb (ir_lsb)
   );

   assign bnd_sel = (ir_q == OP_DRIVE) || (ir_q == OP_SNAP);

   bscan_chain #(.N_CELLS(N_CELLS), .N_LATCH(N_OUT)) u_chain (
      .clk       (test_clk),
      .rst_n     (test_rst_n),
      .cap_en    (bnd_sel && st == ST_DRCAP),
      .shf_en    (bnd_sel && st == ST_DRSHF),
      .upd_en    (bnd_sel && st == ST_DRUPD),
      .din       (ser_in),
      .cap_vec   ({pad_in, core_out}),
      .chain_lsb (chain_lsb),
      .upd_out   (upd_out)
   );

   always_ff @(posedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n)                       byp_q <= 1'b0;
      else if (!bnd_sel && st == ST_DRCAP)   byp_q <= 1'b0;
      else if (!bnd_sel && st == ST_DRSHF)   byp_q <= ser_in;
   end

   assign in_shift = (st == ST_DRSHF) || (st == ST_IRSHF);

   always_ff @(negedge test_clk or negedge test_rst_n) begin
      if (!test_rst_n) begin
         ser_oe  <= 1'b0;
         ser_out <= 1'b0;
      end else begin
         ser_oe  <= in_shift;
         if (st == ST_IRSHF)      ser_out <= ir_lsb;
         else if (st == ST_DRSHF) ser_out <= bnd_sel ? chain_lsb : byp_q;
      end
   end

   assign drive_on = (ir_q == OP_DRIVE) && (st != ST_RESET);
   assign pad_out  = drive_on ? upd_out : core_out;
   assign core_in  = pad_in;

   // R3: serial output is enabled exactly in the shift states
   assert_oe_window_R3: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      ser_oe == (st == ST_DRSHF || st == ST_IRSHF));

   // R5: bypass delays serial data by one clock
   assert_bypass_delay_R5: assert property (@(posedge test_clk) disable iff (!test_rst_n)
      (st == ST_DRSHF && $past(st) == ST_DRSHF && !bnd_sel) |-> (ser_out == $past(ser_in)));

   // R9: pins are functional in Test-Logic-Reset
   assert_reset_functional_R9: assert property (@(negedge test_clk) disable iff (!test_rst_n)
      (st == ST_RESET) |-> (pad_out == core_out));

endmodule

// File: tb/sim_bscan_port.sv
module sim_bscan_port;

   localparam int NI = 4;
   localparam int NO = 4;

   logic          clk = 1'b0;
   logic          test_rst_n;
   logic          mode_sel;
   logic          ser_in;
   logic          ser_out;
   logic          ser_oe;
   logic [NI-1:0] pad_in;
   logic [NI-1:0] core_in;
   logic [NO-1:0] core_out;
   logic [NO-1:0] pad_out;

   always #5 clk = ~clk;

   bscan_port #(.N_IN(NI), .N_OUT(NO), .IR_W(2)) u0 (
      .test_clk   (clk),
      .test_rst_n (test_rst_n),
      .mode_sel   (mode_sel),
      .ser_in     (ser_in),
      .ser_out    (ser_out),
      .ser_oe     (ser_oe),
      .pad_in     (pad_in),
      .core_in    (core_in),
      .core_out   (core_out),
      .pad_out    (pad_out)
   );

   int    errs = 0;
   int    checks = 0;
   bit    done = 0;
   bit    qb[$];
   string qt[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   // scoreboard monitor: every enabled serial bit is compared to the queue head
   always @(negedge clk) begin
      bit    e;
      string t;
      #2;
      if (ser_oe === 1'b1) begin
         if (qb.size() == 0) chk(1'b0, "R3 unexpected serial output", {31'd0, ser_out}, 0);
         else begin
            e = qb.pop_front();
            t = qt.pop_front();
            chk(ser_out === e, t, {31'd0, ser_out}, {31'd0, e});
         end
      end
   end

   task automatic expect_bit(input bit b, input string tag);
      qb.push_back(b);
      qt.push_back(tag);
   endtask

   task automatic tick(input bit tms, input bit tdi);
      mode_sel = tms;
      ser_in   = tdi;
      @(posedge clk);
      #2;
   endtask

   task automatic load_ir(input logic [1:0] code, input bit do_chk, input logic [NO-1:0] hold);
      expect_bit(1'b1, "R4 capture bit0");
      expect_bit(1'b0, "R4 capture bit1");
      tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
      tick(0, code[0]);
      tick(1, code[1]);
      if (do_chk) chk(pad_out === hold, "R4 code not active before Update-IR", pad_out, hold);
      tick(1, 0);
      tick(0, 0);
   endtask

   task automatic scan_dr(input logic [15:0] d, input int len, input bit mid,
                          input logic [NO-1:0] mid_exp, input string tag);
      tick(1, 0); tick(0, 0); tick(0, 0);
      for (int i = 0; i < len; i++) begin
         tick(i == len - 1, d[i]);
         if (mid && i == len / 2) chk(pad_out === mid_exp, tag, pad_out, mid_exp);
      end
      tick(1, 0);
      tick(0, 0);
   endtask

   task automatic expect_cells(input logic [NO-1:0] co, input logic [NI-1:0] pi, input string tag);
      for (int j = 0; j < NO; j++) expect_bit(co[j], tag);
      for (int j = 0; j < NI; j++) expect_bit(pi[j], tag);
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      logic [15:0] d;
      test_rst_n = 1'b0;
      mode_sel   = 1'b1;
      ser_in     = 1'b0;
      core_out   = 4'hA;
      pad_in     = 4'h5;
      #23;
      chk(ser_oe === 1'b0, "R1 reset output enable", {31'd0, ser_oe}, 0);
      chk(pad_out === core_out, "R1 reset pins functional", pad_out, core_out);
      chk(core_in === pad_in, "R10 input passthrough", core_in, pad_in);
      @(posedge clk); #2;
      test_rst_n = 1'b1;
      tick(0, 0);
      chk(ser_oe === 1'b0, "R3 idle output disabled", {31'd0, ser_oe}, 0);

      // bypass is the reset instruction
      d = 16'b101101;
      expect_bit(1'b0, "R5 bypass captures zero");
      for (int i = 0; i < 5; i++) expect_bit(d[i], "R5 bypass one clock delay");
      scan_dr(d, 6, 1, 4'hA, "R5 pins functional in bypass");

      // sample/preload
      load_ir(2'b01, 1, 4'hA);
      expect_cells(4'hA, 4'h5, "R6 snapshot order");
      scan_dr({8'h00, 4'h0, 4'b0110}, NO + NI, 1, 4'hA, "R6 pins functional while preloading");
      chk(pad_out === 4'hA, "R6 preload leaves pins functional", pad_out, 4'hA);
      core_out = 4'h3; #1;
      chk(pad_out === 4'h3, "R6 pins track core", pad_out, 4'h3);

      // drive pins
      load_ir(2'b00, 1, 4'h3);
      chk(pad_out === 4'b0110, "R8 drive preloaded value", pad_out, 4'b0110);
      core_out = 4'hC; #1;
      chk(pad_out === 4'b0110, "R8 core ignored", pad_out, 4'b0110);
      pad_in = 4'h9; #1;
      chk(core_in === 4'h9, "R10 input passthrough under drive", core_in, 4'h9);
      expect_cells(4'hC, 4'h9, "R8 capture under drive");
      scan_dr({8'h00, 4'h0, 4'b1001}, NO + NI, 1, 4'b0110, "R7 no ripple while shifting");
      chk(pad_out === 4'b1001, "R7 update on Update-DR", pad_out, 4'b1001);

      // undefined code behaves as bypass
      load_ir(2'b10, 1, 4'b1001);
      chk(pad_out === 4'hC, "R4 undefined code leaves pins functional", pad_out, 4'hC);
      d = 16'b011;
      expect_bit(1'b0, "R4 undefined code bypass");
      expect_bit(d[0], "R4 undefined code bypass");
      expect_bit(d[1], "R4 undefined code bypass");
      scan_dr(d, 3, 0, 4'h0, "");

      // back to drive pins: latches were kept
      load_ir(2'b00, 0, 4'h0);
      chk(pad_out === 4'b1001, "R7 latches retained", pad_out, 4'b1001);

      // five ones from Shift-DR
      expect_bit(1'b0, "R8 capture under drive");
      tick(1, 0); tick(0, 0); tick(0, 0);
      tick(1, 0); tick(1, 0); tick(1, 0);
      chk(pad_out === 4'hE, "R7 update after one shift", pad_out, 4'hE);
      tick(1, 0);
      chk(pad_out === 4'hE, "R2 not reset after four edges", pad_out, 4'hE);
      tick(1, 0);
      chk(pad_out === 4'hC, "R9 reset state pins functional", pad_out, 4'hC);
      tick(0, 0);
      d = 16'b01;
      expect_bit(1'b0, "R11 bypass after controller reset");
      expect_bit(d[0], "R11 bypass after controller reset");
      scan_dr(d, 2, 0, 4'h0, "");
      chk(pad_out === 4'hC, "R11 pins functional", pad_out, 4'hC);

      // asynchronous reset during shift
      expect_bit(1'b0, "R5 bypass captures zero");
      tick(1, 0); tick(0, 0); tick(0, 0);
      @(negedge clk); #3;
      chk(ser_oe === 1'b1, "R3 shift enables output", {31'd0, ser_oe}, 1);
      test_rst_n = 1'b0; #1;
      chk(ser_oe === 1'b0, "R1 async reset disables output", {31'd0, ser_oe}, 0);
      chk(pad_out === core_out, "R1 async reset pins functional", pad_out, core_out);
      @(posedge clk); #2;
      test_rst_n = 1'b1;
      tick(0, 0);
      expect_bit(1'b0, "R1 bypass after async reset");
      expect_bit(1'b1, "R1 bypass after async reset");
      scan_dr(16'b01, 2, 0, 4'h0, "");

      repeat (3) @(posedge clk);
      chk(qb.size() == 0, "R3 all expected serial bits seen", qb.size(), 0);
      summary();
   end

endmodule